// File: doc/BRIEF.md
# Load Value Forwarding Queue

This block gives two redundant copies of one instruction stream the same load inputs. The leading copy is the only one that reads the data cache. Each time one of its loads commits, it hands the effective address and the returned value to this queue. The trailing copy then takes the entries in program order. It gets each load value without going to the cache, and it presents the address it computed itself so the block can compare that address with the stored one.

A difference between the two addresses means that one of the copies suffered a fault. The block then raises a one-cycle fault pulse, and the entry is still used up so that the trailing copy stays aligned. The leading copy is held off through a ready signal when every slot is occupied. A trailing request that finds no entry waits, and nothing is consumed. The trailing side is only expected to request non-speculatively, one load per request cycle.

Top module: `load_value_fwd_queue`

## Requirements
- R1: After reset `lead_ready_o` is 1 and `trail_ack_o` and `fault_o` are 0.
- R2: Load values reach the trailing side in exactly the order the leading side pushed them.
- R3: When all DEPTH entries are held and `trail_req_i` is 0, `lead_ready_o` is 0 and a push offered in that cycle is not stored.
- R4: A trailing request while the queue is empty gives no acknowledge in the following cycle and consumes nothing.
- R5: When the trailing address equals the head entry's address, `fault_o` stays 0 with the acknowledge.
- R6: When the trailing address differs from the head entry's address, `fault_o` is 1 for exactly the acknowledge cycle, and the entry is still consumed.
- R7: With the queue full, a push and a trailing request in the same cycle are both accepted (`lead_ready_o` is 1), and occupancy stays at DEPTH.
- R8: A trailing request accepted at a clock edge gives `trail_ack_o` = 1 with the head value on `trail_data_o` in the cycle after that edge, for one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lead_valid_i | input | 1 | Leading side offers a committed load |
| lead_ready_o | output | 1 | Queue can take the offered load this cycle |
| lead_addr_i | input | ADDR_W | Leading load effective address |
| lead_data_i | input | DATA_W | Value the leading load read |
| trail_req_i | input | 1 | Trailing side requests its next load value |
| trail_addr_i | input | ADDR_W | Address computed by the trailing side |
| trail_ack_o | output | 1 | Response valid, one cycle after acceptance |
| trail_data_o | output | DATA_W | Forwarded load value |
| fault_o | output | 1 | Address mismatch pulse, aligned with the acknowledge |

## Verification
The bench fills the queue to its limit and offers one more push with no trailing request. A design that stored that push, or overwrote the oldest entry, would return an extra or wrong value when the queue is drained. It drives push and pop together on a full queue, where a design that gated ready on full alone would stall the leading side or drop the new entry. It requests from an empty queue and then checks that the next value is still the first one pushed; a design that advanced its read pointer there would return out-of-order data. It also corrupts one trailing address in the middle of a run to show that the fault pulse lasts only one cycle and that the entry behind it is not skipped.

// File: rtl/lvfq_pkg.sv
package lvfq_pkg;
  localparam int unsigned LVFQ_ADDR_W = 32;
  localparam int unsigned LVFQ_DATA_W = 32;
  localparam int unsigned LVFQ_DEPTH  = 16;
endpackage

// File: rtl/lvfq_ctrl.sv
module lvfq_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_blocks_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |-> !push_i);
  assert_full_swap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && pop_i) |=> full_o);
  assert_no_pop_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/lvfq_mem.sv
module lvfq_mem #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WIDTH  = 64,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) slot_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/lvfq_check.sv
module lvfq_check #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic [ADDR_W-1:0] trail_addr_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      data_o  <= '0;
      fault_o <= 1'b0;
    end else begin
      ack_o   <= pop_i;
      fault_o <= pop_i && (head_addr_i != trail_addr_i);
      if (pop_i) data_o <= head_data_i;
    end
  end

  assert_fault_on_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ack_o);
endmodule

// File: rtl/load_value_fwd_queue.sv
module load_value_fwd_queue
  import lvfq_pkg::*;
#(
  parameter int unsigned ADDR_W = LVFQ_ADDR_W,
  parameter int unsigned DATA_W = LVFQ_DATA_W,
  parameter int unsigned DEPTH  = LVFQ_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lead_valid_i,
  output logic              lead_ready_o,
  input  logic [ADDR_W-1:0] lead_addr_i,
  input  logic [DATA_W-1:0] lead_data_i,
  input  logic              trail_req_i,
  input  logic [ADDR_W-1:0] trail_addr_i,
  output logic              trail_ack_o,
  output logic [DATA_W-1:0] trail_data_o,
  output logic              fault_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned ENT_W = ADDR_W + DATA_W;

  logic             push, pop, empty, full;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [ENT_W-1:0] head;

  // a full queue still accepts when the head leaves in the same cycle
  assign pop          = trail_req_i && !empty;
  assign lead_ready_o = !full || pop;
  assign push         = lead_valid_i && lead_ready_o;

  lvfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .empty_o(empty), .full_o(full)
  );

  lvfq_mem #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_mem (
    .clk_i, .we_i(push), .waddr_i(wr_ptr), .wdata_i({lead_addr_i, lead_data_i}),
    .raddr_i(rd_ptr), .rdata_o(head)
  );

  lvfq_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_check (
    .clk_i, .rst_ni, .pop_i(pop),
    .head_addr_i(head[ENT_W-1:DATA_W]), .head_data_i(head[DATA_W-1:0]),
    .trail_addr_i, .ack_o(trail_ack_o), .data_o(trail_data_o), .fault_o
  );

  assert_ack_follows_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> trail_ack_o);
  assert_no_ack_without_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop |=> !trail_ack_o);
endmodule

// File: tb/load_value_fwd_queue_test.sv
module load_value_fwd_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lead_valid = 1'b0, lead_ready, trail_req = 1'b0, trail_ack, fault;
  logic [AW-1:0] lead_addr = '0, trail_addr = '0;
  logic [DW-1:0] lead_data = '0, trail_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_value_fwd_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lead_valid_i(lead_valid), .lead_ready_o(lead_ready),
    .lead_addr_i(lead_addr), .lead_data_i(lead_data),
    .trail_req_i(trail_req), .trail_addr_i(trail_addr),
    .trail_ack_o(trail_ack), .trail_data_o(trail_data), .fault_o(fault)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
  ent_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, check at the next negedge
  task automatic cycle(input bit lv, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input bit tr, input bit bad_addr);
    bit e_ack = 0, e_fault = 0, rdy, pop;
    logic [DW-1:0] e_data = '0;
    ent_t h;
    ent_t n;
    pop = tr && (sb.size() > 0);
    rdy = (sb.size() < DEPTH) || pop;
    lead_valid = lv; lead_addr = la; lead_data = ld; trail_req = tr;
    trail_addr = '0;
    if (pop) begin
      h = sb[0];
      trail_addr = bad_addr ? (h.a ^ 32'h10) : h.a;
    end
    #1;
    check(lead_ready == rdy, (sb.size() == DEPTH) ? (tr ? "R7" : "R3") : "R1", lead_ready, rdy);
    if (pop) begin
      h = sb.pop_front();
      e_ack = 1; e_data = h.d; e_fault = bad_addr;
    end
    if (lv && rdy) begin n.a = la; n.d = ld; sb.push_back(n); end
    @(posedge clk);
    @(negedge clk);
    check(trail_ack == e_ack, e_ack ? "R8" : "R4", trail_ack, e_ack);
    if (e_ack) begin
      check(trail_data == e_data, "R2", trail_data, e_data);
      check(fault == e_fault, e_fault ? "R6" : "R5", fault, e_fault);
    end else
      check(fault == 1'b0, "R6", fault, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    #(3*CLK_PERIOD + 2);
    @(negedge clk);
    check(lead_ready == 1'b1, "R1", lead_ready, 1);
    check(trail_ack == 1'b0, "R1", trail_ack, 0);
    check(fault == 1'b0, "R1", fault, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: requests on an empty queue
    for (int i = 0; i < 3; i++) cycle(0, '0, '0, 1, 0);
    cycle(1, 32'h100, 32'hA0, 0, 0);
    cycle(0, '0, '0, 1, 0);
    cycle(0, '0, '0, 1, 0);
    // R2/R5: burst then drain
    for (int i = 0; i < 5; i++) cycle(1, 32'h200 + i*4, 32'hB0 + i, 0, 0);
    for (int i = 0; i < 5; i++) cycle(0, '0, '0, 1, 0);
    // R3: fill, then blocked push, then drain plus one
    for (int i = 0; i < DEPTH; i++) cycle(1, 32'h300 + i*4, 32'hC0 + i, 0, 0);
    cycle(1, 32'hDEAD, 32'hBAD, 0, 0);
    for (int i = 0; i <= DEPTH; i++) cycle(0, '0, '0, 1, 0);
    // R7: full with push and pop together
    for (int i = 0; i < DEPTH; i++) cycle(1, 32'h400 + i*4, 32'hD0 + i, 0, 0);
    cycle(1, 32'h4FC, 32'hEE, 1, 0);
    cycle(1, 32'h500, 32'hEF, 0, 0);
    for (int i = 0; i <= DEPTH; i++) cycle(0, '0, '0, 1, 0);
    // R6: mismatch in the middle
    for (int i = 0; i < 3; i++) cycle(1, 32'h600 + i*4, 32'hF0 + i, 0, 0);
    cycle(0, '0, '0, 1, 0);
    cycle(0, '0, '0, 1, 1);
    cycle(0, '0, '0, 1, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cycle(lfsr[0], {16'h7, lfsr[15:0]}, lfsr, lfsr[3] | lfsr[5], lfsr[9] & lfsr[11] & lfsr[13]);
    end
    while (sb.size() > 0) cycle(0, '0, '0, 1, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule